// File: doc/BRIEF.md
# DRAM Access and Refresh Controller

This block turns word requests that fall in a DRAM region into the strobe and address sequences a DRAM array expects. For each request it drives a row address with RAS low, then a column address with CAS low. Write enable is driven from the request's direction. The split between row and column bits follows a capacity setting of 8, 9 or 10 column bits. A requester holds `req`, `req_we` and `req_addr` steady until `ack` pulses.

Two settings can keep a row open after an access. In page mode the row stays open only when the next request, for the same row, is already waiting in the cycle after `ack`. That request then gets a new column and a new CAS pulse and no new row phase. In RAS-held mode the row stays open while the controller is idle. A request for a different row first closes the row and waits out a precharge period.

An 8-bit counter counts clock cycles and is compared with a programmable value. On a match the counter returns to zero and a sticky flag is set. The flag raises an interrupt when the interrupt is enabled, so the counter works as an interval timer. When refresh is enabled, each match also schedules a CAS-before-RAS refresh. On software command the controller enters self-refresh and holds both strobes low until the command is withdrawn.

Top module: `dram_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it rises, `ras_n`, `cas_n` and `we_n` are 1, and `ack`, `self_active`, `tmr_flag` and `tmr_irq` are 0.
- R2: An access to a closed row gives three states, one cycle each. First `ras_n`=0 with `cas_n`=1. Next `cas_n`=0 with `we_n`=0 for a write (`req_we`=1) or 1 for a read. Last `cas_n`=1 with `ack`=1 for exactly one cycle. If page mode and RAS-held mode are both off, `ras_n` is 1 in the cycle after `ack`.
- R3: `cfg_col_sel` 0, 1, 2 and 3 select 8, 9, 10 and 10 column bits (C). In the RAS state `ma` carries bits [C+9:C] of `req_addr`. In the CAS state `ma` carries bits [C-1:0], zero-extended.
- R4: In page mode, a request for the same row that is present in the cycle after `ack` is served with `ras_n` held low: one cycle with both strobes idle-high/low (`ras_n`=0, `cas_n`=1), then a CAS state with the new column. With no request waiting, `ras_n` rises one cycle later.
- R5: In RAS-held mode, `ras_n` stays 0 while idle after an access. A later request for the same row goes straight to the CAS state one cycle after `req` is raised.
- R6: A request for a different row while a row is open sets `ras_n`=1 for TRP+1 cycles (TRP=2 by default). The new row's RAS state follows, with the new row on `ma`.
- R7: The counter advances by one each cycle and goes to 0 in the cycle after it equals `tmr_cmp`, which gives a period of `tmr_cmp`+1 cycles. `tmr_flag` is set one cycle after the match and stays set until `flag_clr` is pulsed.
- R8: `tmr_irq` equals `tmr_flag` AND `cfg_irq_en`.
- R9: With `cfg_rf_en`=1, each match schedules a refresh. The refresh starts once any access has ended and any open row has been closed through the precharge period. It then runs one cycle each of: `cas_n`=0 with `ras_n`=1, both 0, `cas_n`=0 with `ras_n`=1. Last comes `cas_n`=1, and `we_n` stays 1 throughout.
- R10: Raising `self_req` while idle gives one cycle of `cas_n`=0 with `ras_n`=1, then both 0 with `self_active`=1 for as long as `self_req` stays high. Requests get no `ack` during this time. Dropping `self_req` gives one cycle of `ras_n`=1 with `cas_n`=0, then both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_col_sel | input | 2 | Column-bit count select (8/9/10/10) |
| cfg_page_mode | input | 1 | Page mode enable |
| cfg_ras_down | input | 1 | RAS-held mode enable |
| cfg_rf_en | input | 1 | Refresh on compare match enable |
| cfg_irq_en | input | 1 | Compare-match interrupt enable |
| tmr_cmp | input | CNT_W | Compare value |
| flag_clr | input | 1 | Clears the match flag |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write |
| req_addr | input | ADDR_W | Access byte/word address |
| self_req | input | 1 | Self-refresh command |
| ack | output | 1 | Access done pulse |
| ma | output | MA_W | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| self_active | output | 1 | Self-refresh hold in progress |
| tmr_flag | output | 1 | Sticky compare-match flag |
| tmr_irq | output | 1 | Compare-match interrupt |

## Verification
A wrong state in the access sequencer shows at the ports within one cycle. It appears as a misplaced strobe edge, a row where a column belongs, or an `ack` in the wrong cycle. The bench compares every cycle of each sequence against the requirement. A stored open row that is wrong gives either an unwanted precharge (three high cycles of `ras_n`) or a missing one, on the very next request. A counter or flag fault moves the match by at least one cycle, which the exact-cycle check of the flag rise detects within one timer period.

// File: rtl/dram_pkg.sv
package dram_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RAS,
        ST_COL,
        ST_END,
        ST_OPEN,
        ST_PRE,
        ST_RFC,
        ST_RFR,
        ST_RFH,
        ST_SRC,
        ST_SRH,
        ST_SRX
    } acc_st_e;

    // number of column bits for a capacity select code
    function automatic int unsigned col_bits(input logic [1:0] sel);
        case (sel)
            2'd0:    return 8;
            2'd1:    return 9;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
    parameter int ADDR_W = 24,
    parameter int MA_W   = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        col_sel,
    output logic [ADDR_W-1:0] row_key,
    output logic [MA_W-1:0]   row_ma,
    output logic [MA_W-1:0]   col_ma
);
    int unsigned       cb;
    logic [ADDR_W-1:0] mask;

    always_comb begin
        cb      = dram_pkg::col_bits(col_sel);
        mask    = (ADDR_W'(1) << cb) - ADDR_W'(1);
        row_key = addr >> cb;
        row_ma  = row_key[MA_W-1:0];
        col_ma  = MA_W'(addr & mask);
    end

    initial begin
        a_r3_ma_wide_enough: assert (MA_W >= 10);
    end
endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cmp,
    input  logic             rf_en,
    input  logic             irq_en,
    input  logic             flag_clr,
    input  logic             rf_ack,
    output logic             flag,
    output logic             irq,
    output logic             rf_req
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
        logic             rq;
    } tmr_t;

    tmr_t q, d;
    logic hit;

    always_comb begin
        d   = q;
        hit = (q.cnt == cmp);
        if (flag_clr) d.flag = 1'b0;
        if (rf_ack)   d.rq   = 1'b0;
        if (hit) begin
            d.cnt  = '0;
            d.flag = 1'b1;
            if (rf_en) d.rq = 1'b1;
        end else begin
            d.cnt = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flag   = q.flag;
    assign irq    = q.flag & irq_en;
    assign rf_req = q.rq;

    a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == cmp) |=> (q.cnt == '0));
    a_r7_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == cmp) |=> flag);
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);
endmodule

// File: rtl/dram_access_fsm.sv
module dram_access_fsm
    import dram_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int MA_W   = 10,
    parameter int TRP    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] row_key,
    input  logic [MA_W-1:0]   row_ma,
    input  logic [MA_W-1:0]   col_ma,
    input  logic              page_mode,
    input  logic              ras_down,
    input  logic              rf_req,
    input  logic              self_req,
    output logic              rf_ack,
    output logic              ack,
    output logic [MA_W-1:0]   ma,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              self_active
);
    localparam int TW = (TRP > 1) ? $clog2(TRP) : 1;

    typedef struct packed {
        acc_st_e           st;
        logic [ADDR_W-1:0] open_row;
        logic [TW-1:0]     wt;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d      = q;
        rf_ack = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (self_req) begin
                    d.st = ST_SRC;
                end else if (rf_req) begin
                    d.st   = ST_RFC;
                    rf_ack = 1'b1;
                end else if (req) begin
                    d.st       = ST_RAS;
                    d.open_row = row_key;
                end
            end
            ST_RAS: d.st = ST_COL;
            ST_COL: d.st = ST_END;
            ST_END: begin
                if (page_mode || ras_down) begin
                    d.st = ST_OPEN;
                end else begin
                    d.st = ST_PRE;
                    d.wt = TW'(TRP - 1);
                end
            end
            ST_OPEN: begin
                if (!self_req && !rf_req && req && row_key == q.open_row) begin
                    d.st = ST_COL;
                end else if (self_req || rf_req || req || !ras_down) begin
                    d.st = ST_PRE;
                    d.wt = TW'(TRP - 1);
                end
            end
            ST_PRE: begin
                if (q.wt == '0) d.st = ST_IDLE;
                else            d.wt = q.wt - TW'(1);
            end
            ST_RFC: d.st = ST_RFR;
            ST_RFR: d.st = ST_RFH;
            ST_RFH: d.st = ST_IDLE;
            ST_SRC: d.st = ST_SRH;
            ST_SRH: if (!self_req) d.st = ST_SRX;
            ST_SRX: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= ST_IDLE;
            q.open_row <= '0;
            q.wt       <= '0;
        end else begin
            q <= d;
        end
    end

    // output decode from the registered state
    always_comb begin
        ras_n       = !(q.st inside {ST_RAS, ST_COL, ST_END, ST_OPEN, ST_RFR, ST_SRH});
        cas_n       = !(q.st inside {ST_COL, ST_RFC, ST_RFR, ST_RFH, ST_SRC, ST_SRH, ST_SRX});
        we_n        = !(q.st == ST_COL && req_we);
        ack         = (q.st == ST_END);
        self_active = (q.st == ST_SRH);
        case (q.st)
            ST_RAS:  ma = row_ma;
            ST_COL:  ma = col_ma;
            default: ma = '0;
        endcase
    end

    a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    a_r9_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> $past(!cas_n));
    a_r6_precharge_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> ras_n);
    a_r10_self_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (self_active && self_req) |=> self_active);
    a_r2_write_needs_cas: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!cas_n && !ras_n));
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
    parameter int ADDR_W = 24,
    parameter int MA_W   = 10,
    parameter int CNT_W  = 8,
    parameter int TRP    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_col_sel,
    input  logic              cfg_page_mode,
    input  logic              cfg_ras_down,
    input  logic              cfg_rf_en,
    input  logic              cfg_irq_en,
    input  logic [CNT_W-1:0]  tmr_cmp,
    input  logic              flag_clr,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              self_req,
    output logic              ack,
    output logic [MA_W-1:0]   ma,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              self_active,
    output logic              tmr_flag,
    output logic              tmr_irq
);
    logic [ADDR_W-1:0] row_key;
    logic [MA_W-1:0]   row_ma, col_ma;
    logic              rf_req, rf_ack;

    dram_addr_split #(.ADDR_W(ADDR_W), .MA_W(MA_W)) u_split (
        .addr    (req_addr),
        .col_sel (cfg_col_sel),
        .row_key (row_key),
        .row_ma  (row_ma),
        .col_ma  (col_ma)
    );

    dram_refresh_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp      (tmr_cmp),
        .rf_en    (cfg_rf_en),
        .irq_en   (cfg_irq_en),
        .flag_clr (flag_clr),
        .rf_ack   (rf_ack),
        .flag     (tmr_flag),
        .irq      (tmr_irq),
        .rf_req   (rf_req)
    );

    dram_access_fsm #(.ADDR_W(ADDR_W), .MA_W(MA_W), .TRP(TRP)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .req_we      (req_we),
        .row_key     (row_key),
        .row_ma      (row_ma),
        .col_ma      (col_ma),
        .page_mode   (cfg_page_mode),
        .ras_down    (cfg_ras_down),
        .rf_req      (rf_req),
        .self_req    (self_req),
        .rf_ack      (rf_ack),
        .ack         (ack),
        .ma          (ma),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .we_n        (we_n),
        .self_active (self_active)
    );

    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_irq |-> (cfg_irq_en && tmr_flag));
    a_r10_no_ack_in_self: assert property (@(posedge clk) disable iff (!rst_n)
        self_active |-> !ack);
endmodule

// File: tb/dram_ctrl_test.sv
`timescale 1ns/1ps
module dram_ctrl_test;
    localparam int ADDR_W = 24;
    localparam int MA_W   = 10;
    localparam int CNT_W  = 8;
    localparam int TRP    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_col_sel = 2'd0;
    logic cfg_page_mode = 1'b0, cfg_ras_down = 1'b0, cfg_rf_en = 1'b0, cfg_irq_en = 1'b0;
    logic [CNT_W-1:0] tmr_cmp = 8'd255;
    logic flag_clr = 1'b0, req = 1'b0, req_we = 1'b0, self_req = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic ack, ras_n, cas_n, we_n, self_active, tmr_flag, tmr_irq;
    logic [MA_W-1:0] ma;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    dram_ctrl #(.ADDR_W(ADDR_W), .MA_W(MA_W), .CNT_W(CNT_W), .TRP(TRP)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_col_sel(cfg_col_sel), .cfg_page_mode(cfg_page_mode),
        .cfg_ras_down(cfg_ras_down), .cfg_rf_en(cfg_rf_en), .cfg_irq_en(cfg_irq_en),
        .tmr_cmp(tmr_cmp), .flag_clr(flag_clr), .req(req), .req_we(req_we),
        .req_addr(req_addr), .self_req(self_req), .ack(ack), .ma(ma), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .self_active(self_active), .tmr_flag(tmr_flag),
        .tmr_irq(tmr_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int unsigned cbits(input logic [1:0] sel);
        return (sel == 2'd3) ? 10 : 8 + int'(sel);
    endfunction
    function automatic logic [MA_W-1:0] exp_row(input logic [1:0] sel, input logic [ADDR_W-1:0] a);
        return MA_W'((a >> cbits(sel)) % 1024);
    endfunction
    function automatic logic [MA_W-1:0] exp_col(input logic [1:0] sel, input logic [ADDR_W-1:0] a);
        return MA_W'(a % (24'd1 << cbits(sel)));
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R1 ras_n in reset", ras_n, 1);
        chk("R1 cas_n in reset", cas_n, 1);
        chk("R1 we_n in reset", we_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ack after reset", ack, 0);
        chk("R1 flag/irq/self after reset", {tmr_flag, tmr_irq, self_active}, 0);
        chk("R1 strobes after reset", {ras_n, cas_n, we_n}, 3'b111);
    endtask

    task automatic t_closed(input logic [1:0] sel, input logic [ADDR_W-1:0] a, input logic w);
        @(negedge clk);
        cfg_col_sel = sel; req = 1'b1; req_we = w; req_addr = a;
        @(negedge clk);
        chk("R2 row phase strobes", {ras_n, cas_n}, 2'b01);
        chk("R3 row address", ma, exp_row(sel, a));
        @(negedge clk);
        chk("R2 column phase strobes", {ras_n, cas_n}, 2'b00);
        chk("R3 column address", ma, exp_col(sel, a));
        chk("R2 write enable", we_n, !w);
        @(negedge clk);
        chk("R2 ack with cas high", {ack, cas_n, ras_n}, 3'b110);
        req = 1'b0;
        @(negedge clk);
        chk("R2 single ack and precharge", {ack, ras_n}, 2'b01);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_page();
        cfg_page_mode = 1'b1;
        @(negedge clk);
        cfg_col_sel = 2'd0; req = 1'b1; req_we = 1'b0; req_addr = 24'h000A10;
        repeat (3) @(negedge clk);
        chk("R4 first ack", ack, 1);
        req_addr = 24'h000A3C; req_we = 1'b1;
        @(negedge clk);
        chk("R4 row held open", {ras_n, cas_n}, 2'b01);
        @(negedge clk);
        chk("R4 column only", {ras_n, cas_n, we_n}, 3'b000);
        chk("R4 new column", ma, 10'h03C);
        @(negedge clk);
        chk("R4 second ack", ack, 1);
        req = 1'b0;
        @(negedge clk);
        chk("R4 open one cycle", ras_n, 0);
        @(negedge clk);
        chk("R4 closes without request", ras_n, 1);
        cfg_page_mode = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_rasdown();
        int hi;
        cfg_ras_down = 1'b1;
        @(negedge clk);
        cfg_col_sel = 2'd0; req = 1'b1; req_we = 1'b0; req_addr = 24'h001520;
        repeat (3) @(negedge clk);
        req = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R5 ras held low while idle", {ras_n, cas_n}, 2'b01);
        end
        req = 1'b1; req_addr = 24'h0015FF;
        @(negedge clk);
        chk("R5 same row goes to column", {ras_n, cas_n}, 2'b00);
        chk("R5 same row column", ma, 10'h0FF);
        @(negedge clk);
        chk("R5 ack", ack, 1);
        req = 1'b0;
        @(negedge clk);
        req = 1'b1; req_addr = 24'h002201;
        hi = 0;
        @(negedge clk);
        while (ras_n && hi < 20) begin
            hi++;
            @(negedge clk);
        end
        chk("R6 precharge length", hi, TRP + 1);
        chk("R6 new row address", ma, 10'h022);
        repeat (2) @(negedge clk);
        chk("R6 ack", ack, 1);
        req = 1'b0; cfg_ras_down = 1'b0;
        repeat (6) @(negedge clk);
        chk("R6 row closed", ras_n, 1);
    endtask

    task automatic t_timer();
        int n;
        @(negedge clk);
        cfg_irq_en = 1'b0; tmr_cmp = 8'd9; flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        n = 0;
        while (!tmr_flag && n < 600) begin
            n++;
            @(negedge clk);
        end
        chk("R7 flag rises", tmr_flag, 1);
        chk("R8 irq masked", tmr_irq, 0);
        flag_clr = 1'b1; cfg_irq_en = 1'b1;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            flag_clr = 1'b0;
            if (k == 9)  chk("R7 no match before period", {tmr_flag, tmr_irq}, 2'b00);
            if (k == 10) chk("R7 R8 match after cmp+1", {tmr_flag, tmr_irq}, 2'b11);
        end
        repeat (25) @(negedge clk);
        chk("R7 flag sticky", tmr_flag, 1);
        cfg_irq_en = 1'b0;
        @(negedge clk);
        chk("R8 irq follows enable", tmr_irq, 0);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0; tmr_cmp = 8'd255;
    endtask

    task automatic cbr_tail(input string tag);
        @(negedge clk);
        chk({tag, " both low"}, {ras_n, cas_n}, 2'b00);
        @(negedge clk);
        chk({tag, " ras up cas low"}, {ras_n, cas_n}, 2'b10);
        @(negedge clk);
        chk({tag, " cas up"}, {ras_n, cas_n, we_n}, 3'b111);
    endtask

    task automatic t_refresh_idle();
        int n;
        @(negedge clk);
        tmr_cmp = 8'd30; cfg_rf_en = 1'b1;
        n = 0;
        while (cas_n && n < 600) begin
            n++;
            @(negedge clk);
        end
        chk("R9 cas first, ras high", {ras_n, cas_n, we_n}, 3'b101);
        cbr_tail("R9 idle refresh");
        cfg_rf_en = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic t_refresh_open();
        int n;
        int hi;
        cfg_ras_down = 1'b1;
        @(negedge clk);
        cfg_col_sel = 2'd1; req = 1'b1; req_we = 1'b0; req_addr = 24'h004321;
        repeat (3) @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        chk("R9 row open before refresh", ras_n, 0);
        tmr_cmp = 8'd30; cfg_rf_en = 1'b1;
        n = 0;
        while (!ras_n && n < 600) begin
            n++;
            @(negedge clk);
        end
        hi = 0;
        while (cas_n && hi < 20) begin
            hi++;
            @(negedge clk);
        end
        chk("R9 row closed and precharged first", hi, TRP + 1);
        chk("R9 cas first after close", {ras_n, cas_n}, 2'b10);
        cbr_tail("R9 open-row refresh");
        cfg_rf_en = 1'b0; cfg_ras_down = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic t_self();
        int acks;
        @(negedge clk);
        self_req = 1'b1;
        @(negedge clk);
        chk("R10 entry cas first", {ras_n, cas_n}, 2'b10);
        @(negedge clk);
        chk("R10 hold both low", {ras_n, cas_n, self_active}, 3'b001);
        req = 1'b1; req_addr = 24'h000100;
        acks = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (ack || ras_n || cas_n || !self_active) acks++;
        end
        chk("R10 held and requests unserved", acks, 0);
        self_req = 1'b0; req = 1'b0;
        @(negedge clk);
        chk("R10 exit ras first", {ras_n, cas_n, self_active}, 3'b100);
        @(negedge clk);
        chk("R10 exit cas up", {ras_n, cas_n}, 2'b11);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(500000.0);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_closed(2'd0, 24'h123456, 1'b0);
        t_closed(2'd1, 24'h123456, 1'b1);
        t_closed(2'd2, 24'h123456, 1'b0);
        t_closed(2'd3, 24'hABCDEF, 1'b1);
        t_page();
        t_rasdown();
        t_timer();
        t_refresh_idle();
        t_refresh_open();
        t_self();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule